// File: doc/BRIEF.md
# Camera Byte Capture to Frame Buffer

This block takes the parallel byte stream of an image sensor and turns it into pixel words for a small frame buffer. The sensor's pixel clock is the block's own clock. A frame-sync pulse marks the start of a frame. A line-valid level marks the bytes that belong to a line. Each byte is presented for a fixed slot of several clock cycles, and the block samples it at one fixed phase inside that slot. Two bytes in a row form one 16-bit word that carries a 12-bit RGB pixel. The word is then written to the buffer through a write address, write data and a one-cycle write enable.

The buffer geometry comes from parameters. By default the frame is 80 by 60 pixels, which gives 4800 words. Addresses run upward from zero after every frame-sync rising edge. Once the final address has been written, any further words in that frame are dropped. A freeze input suppresses writes while the address keeps counting, so capture stays aligned when freeze is released in the middle of a frame. A surveillance input limits live writes to the top half of the buffer. The bottom half then keeps whatever frame it last held, and can serve as a stored reference picture.

Top module: `cam_capture_fb`

## Requirements
- R1: While reset is asserted and in the first cycle after it, wr_en is 0, wr_addr is 0 and wr_data is 0.
- R2: Counting from the cycle in which cam_href is first seen high, each byte occupies BYTE_CYCLES (default 4) cycles. The byte is sampled on the clock edge at phase SAMPLE_PH (default 1, the second cycle of the slot). Values of cam_byte at other phases, or while cam_href is low, never reach wr_data.
- R3: The first byte of a pair goes to wr_data[15:8] and the second to wr_data[7:0]. Bits 15:12 are then forced to 0, so only the 12-bit RGB field in bits 11:0 is kept. wr_en is high for the single cycle right after the clock edge that samples the second byte.
- R4: Pairing restarts at the start of every line. A lone final byte in a line (odd count) is discarded and produces no write.
- R5: After each cam_vsync rising edge, the words of the frame are written to consecutive addresses starting at 0.
- R6: At most DEPTH (FRAME_W*FRAME_H) words are written per frame. Words after address DEPTH-1 produce no write until the next cam_vsync rising edge.
- R7: While freeze is high, no write occurs. A word suppressed this way still uses up its address.
- R8: While surv_en is high, live writes only reach addresses below DEPTH/2. Words after that point in the frame produce no write.
- R9: wr_en is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock, also the block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cam_byte | input | 8 | Sensor data byte |
| cam_vsync | input | 1 | Frame sync; its rising edge restarts the address |
| cam_href | input | 1 | Line valid; bytes are accepted only while high |
| freeze | input | 1 | Suppresses buffer writes while high |
| surv_en | input | 1 | Restricts live writes to the top half of the buffer |
| wr_en | output | 1 | One-cycle write strobe |
| wr_addr | output | ADDR_W (13) | Buffer write address |
| wr_data | output | 16 | Pixel word, 12-bit RGB in bits 11:0 |

## Verification
The bench builds the block with an 8 by 4 frame, so DEPTH is 32 and the surveillance limit is 16. The slot stays at 4 cycles, sampled at phase 1. With this small geometry, a frame of a few short lines runs past the final address and past the half-buffer limit. The overflow and surveillance cut-offs are therefore hit many times in each run, and random frames of varying length, odd byte counts and freeze settings per line mix with directed frames at exactly those limits.

// File: rtl/cap_pkg.sv
package cap_pkg;

   typedef enum logic {
      SEL_FIRST  = 1'b0,
      SEL_SECOND = 1'b1
   } byte_sel_e;

   function automatic logic [31:0] low_mask(input int bits);
      return (32'd1 << bits) - 32'd1;
   endfunction

endpackage

// File: rtl/cap_phase.sv
module cap_phase #(
   parameter int BYTE_CYCLES = 4,
   parameter int SAMPLE_PH   = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic href,
   output logic strobe
);
   localparam int PH_W = (BYTE_CYCLES > 1) ? $clog2(BYTE_CYCLES) : 1;

   generate
      if (BYTE_CYCLES == 1) begin : g_every
         assign strobe = href;
      end else begin : g_count
         localparam logic [PH_W-1:0] PH_LAST   = PH_W'(BYTE_CYCLES - 1);
         localparam logic [PH_W-1:0] PH_SAMPLE = PH_W'(SAMPLE_PH);
         logic [PH_W-1:0] ph;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ph <= '0;
            end else if (!href) begin
               ph <= '0;
            end else if (ph == PH_LAST) begin
               ph <= '0;
            end else begin
               ph <= ph + 1'b1;
            end
         end

         assign strobe = href && (ph == PH_SAMPLE);
      end
   endgenerate
endmodule

// File: rtl/cap_pair.sv
module cap_pair
   import cap_pkg::*;
#(
   parameter int BYTE_W     = 8,
   parameter int PIX_BITS   = 12,
   parameter bit HIGH_FIRST = 1'b1,
   localparam int WORD_W    = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              href,
   input  logic              strobe,
   input  logic              frame_start,
   input  logic [BYTE_W-1:0] byte_in,
   output logic              word_valid,
   output logic [WORD_W-1:0] word
);
   localparam logic [WORD_W-1:0] MASK = WORD_W'(low_mask(PIX_BITS));

   byte_sel_e         sel;
   logic [BYTE_W-1:0] first_q;
   logic [WORD_W-1:0] raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel     <= SEL_FIRST;
         first_q <= '0;
      end else if (frame_start || !href) begin
         sel <= SEL_FIRST;
      end else if (strobe) begin
         if (sel == SEL_FIRST) begin
            first_q <= byte_in;
            sel     <= SEL_SECOND;
         end else begin
            sel <= SEL_FIRST;
         end
      end
   end

   generate
      if (HIGH_FIRST) begin : g_hi_first
         assign raw = {first_q, byte_in};
      end else begin : g_lo_first
         assign raw = {byte_in, first_q};
      end
   endgenerate

   assign word_valid = strobe && href && !frame_start && (sel == SEL_SECOND);
   assign word       = raw & MASK;
endmodule

// File: rtl/cap_addr.sv
module cap_addr #(
   parameter int DEPTH  = 4800,
   parameter int WORD_W = 16,
   localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              word_valid,
   input  logic [WORD_W-1:0] word,
   input  logic              freeze,
   input  logic              surv,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [WORD_W-1:0] wr_data
);
   localparam logic [CNT_W-1:0] LIM_FULL = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] LIM_HALF = CNT_W'(DEPTH / 2);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;
   logic             in_range;

   assign limit    = surv ? LIM_HALF : LIM_FULL;
   assign in_range = cnt < limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
      end else if (frame_start) begin
         cnt   <= '0;
         wr_en <= 1'b0;
      end else if (word_valid) begin
         wr_en <= in_range && !freeze;
         if (in_range) begin
            cnt <= cnt + 1'b1;
            if (!freeze) begin
               wr_addr <= cnt[ADDR_W-1:0];
               wr_data <= word;
            end
         end
      end else begin
         wr_en <= 1'b0;
      end
   end
endmodule

// File: rtl/cam_capture_fb.sv
module cam_capture_fb #(
   parameter int FRAME_W     = 80,
   parameter int FRAME_H     = 60,
   parameter int BYTE_W      = 8,
   parameter int PIX_BITS    = 12,
   parameter int BYTE_CYCLES = 4,
   parameter int SAMPLE_PH   = 1,
   parameter bit HIGH_FIRST  = 1'b1,
   localparam int DEPTH  = FRAME_W * FRAME_H,
   localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int WORD_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BYTE_W-1:0] cam_byte,
   input  logic              cam_vsync,
   input  logic              cam_href,
   input  logic              freeze,
   input  logic              surv_en,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [WORD_W-1:0] wr_data
);
   generate
      if (FRAME_W < 1 || FRAME_H < 2) begin : g_bad_geom
         $error("cam_capture_fb: frame must be at least 1 x 2");
      end
      if ((FRAME_H % 2) != 0) begin : g_bad_half
         $error("cam_capture_fb: FRAME_H must be even for the half-buffer mode");
      end
      if (BYTE_CYCLES < 1) begin : g_bad_slot
         $error("cam_capture_fb: BYTE_CYCLES must be at least 1");
      end
      if (SAMPLE_PH < 0 || SAMPLE_PH >= BYTE_CYCLES) begin : g_bad_phase
         $error("cam_capture_fb: SAMPLE_PH must lie inside the byte slot");
      end
      if (PIX_BITS < 1 || PIX_BITS > WORD_W) begin : g_bad_pix
         $error("cam_capture_fb: PIX_BITS must fit the word");
      end
   endgenerate

   logic              vs_q;
   logic              frame_start;
   logic              strobe;
   logic              word_valid;
   logic [WORD_W-1:0] word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vs_q <= 1'b0;
      end else begin
         vs_q <= cam_vsync;
      end
   end

   assign frame_start = cam_vsync && !vs_q;

   cap_phase #(
      .BYTE_CYCLES(BYTE_CYCLES),
      .SAMPLE_PH  (SAMPLE_PH)
   ) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .href  (cam_href),
      .strobe(strobe)
   );

   cap_pair #(
      .BYTE_W    (BYTE_W),
      .PIX_BITS  (PIX_BITS),
      .HIGH_FIRST(HIGH_FIRST)
   ) u_pair (
      .clk        (clk),
      .rst_n      (rst_n),
      .href       (cam_href),
      .strobe     (strobe),
      .frame_start(frame_start),
      .byte_in    (cam_byte),
      .word_valid (word_valid),
      .word       (word)
   );

   cap_addr #(
      .DEPTH (DEPTH),
      .WORD_W(WORD_W)
   ) u_addr (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_start(frame_start),
      .word_valid (word_valid),
      .word       (word),
      .freeze     (freeze),
      .surv       (surv_en),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data)
   );
endmodule

// File: rtl/cam_capture_chk.sv
module cam_capture_chk #(
   parameter int DEPTH    = 4800,
   parameter int PIX_BITS = 12,
   parameter int ADDR_W   = 13,
   parameter int WORD_W   = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              freeze,
   input logic              surv_en,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [WORD_W-1:0] wr_data
);
   localparam logic [WORD_W-1:0] MASK = WORD_W'(cap_pkg::low_mask(PIX_BITS));

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (!wr_en && wr_addr == '0 && wr_data == '0));

   assert_pix_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ((wr_data & ~MASK) == '0));

   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_addr) < DEPTH));

   assert_freeze_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !$past(freeze));

   assert_top_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && $past(surv_en)) |-> (int'(wr_addr) < DEPTH / 2));

   assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);
endmodule

bind cam_capture_fb cam_capture_chk #(
   .DEPTH   (DEPTH),
   .PIX_BITS(PIX_BITS),
   .ADDR_W  (ADDR_W),
   .WORD_W  (WORD_W)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .freeze (freeze),
   .surv_en(surv_en),
   .wr_en  (wr_en),
   .wr_addr(wr_addr),
   .wr_data(wr_data)
);

// File: tb/sim_cam_capture_fb.sv
`timescale 1ns/1ps
module sim_cam_capture_fb;
   localparam int FW = 8;
   localparam int FH = 4;
   localparam int DEPTH = FW * FH;
   localparam int HALF = DEPTH / 2;
   localparam int AW = $clog2(DEPTH);
   localparam int MAXW = 512;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    cam_byte = 8'h00;
   logic          cam_vsync = 1'b0;
   logic          cam_href = 1'b0;
   logic          freeze = 1'b0;
   logic          surv_en = 1'b0;
   logic          wr_en;
   logic [AW-1:0] wr_addr;
   logic [15:0]   wr_data;

   always #2 clk = ~clk;

   cam_capture_fb #(
      .FRAME_W(FW), .FRAME_H(FH), .BYTE_W(8), .PIX_BITS(12),
      .BYTE_CYCLES(4), .SAMPLE_PH(1), .HIGH_FIRST(1'b1)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .cam_byte(cam_byte), .cam_vsync(cam_vsync),
      .cam_href(cam_href), .freeze(freeze), .surv_en(surv_en),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
   );

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   int        obs_n = 0;
   int        obs_addr [MAXW];
   logic [15:0] obs_data [MAXW];
   int        exp_n = 0;
   int        exp_addr [MAXW];
   logic [15:0] exp_data [MAXW];
   int        m_addr = 0;
   bit        prev_en = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_en && prev_en) begin
            tests++; fails++;
            $display("FAIL R9: wr_en high two cycles, act=1 exp=0");
         end
         if (wr_en && obs_n < MAXW) begin
            obs_addr[obs_n] = int'(wr_addr);
            obs_data[obs_n] = wr_data;
            obs_n++;
         end
      end
      prev_en = wr_en;
   end

   task automatic check(input bit ok, input string tag, input int act, input int expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: act=%0h exp=%0h", tag, act, expv);
      end
   endtask

   function automatic logic [15:0] pack_px(input logic [7:0] a, input logic [7:0] b);
      return {a, b} & 16'h0FFF;
   endfunction

   task automatic start_frame(input bit surv);
      @(negedge clk);
      surv_en = surv;
      cam_vsync = 1'b1;
      repeat (2) @(negedge clk);
      cam_vsync = 1'b0;
      repeat (2) @(negedge clk);
      obs_n = 0;
      exp_n = 0;
      m_addr = 0;
   endtask

   task automatic send_line(input int nbytes, input bit frz);
      logic [7:0] first;
      bit have;
      int lim;
      lim = surv_en ? HALF : DEPTH;
      have = 1'b0;
      first = 8'h00;
      freeze = frz;
      for (int i = 0; i < nbytes; i++) begin
         logic [7:0] b;
         b = 8'($urandom);
         cam_href = 1'b1;
         for (int c = 0; c < 4; c++) begin
            cam_byte = (c == 1 || c == 0) ? b : 8'($urandom);
            @(negedge clk);
         end
         if (!have) begin
            first = b;
            have = 1'b1;
         end else begin
            have = 1'b0;
            if (m_addr < lim) begin
               if (!frz) begin
                  exp_addr[exp_n] = m_addr;
                  exp_data[exp_n] = pack_px(first, b);
                  exp_n++;
               end
               m_addr++;
            end
         end
      end
      cam_href = 1'b0;
      for (int g = 0; g < 3; g++) begin
         cam_byte = 8'($urandom);
         @(negedge clk);
      end
   endtask

   task automatic end_frame(input string tag);
      repeat (3) @(negedge clk);
      check(obs_n == exp_n, tag, obs_n, exp_n);
      for (int k = 0; k < exp_n && k < obs_n; k++) begin
         check(obs_addr[k] == exp_addr[k], "R5", obs_addr[k], exp_addr[k]);
         check(obs_data[k] == exp_data[k], "R3", int'(obs_data[k]), int'(exp_data[k]));
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check(wr_en == 1'b0, "R1", int'(wr_en), 0);
      check(wr_addr == '0, "R1", int'(wr_addr), 0);
      check(wr_data == 16'h0, "R1", int'(wr_data), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(wr_en == 1'b0 && wr_data == 16'h0, "R1", int'(wr_en), 0);

      // R2 R3 R5: plain short frame
      start_frame(1'b0);
      send_line(6, 1'b0);
      send_line(8, 1'b0);
      end_frame("R2");

      // R4: odd byte counts drop the lone byte
      start_frame(1'b0);
      send_line(5, 1'b0);
      send_line(3, 1'b0);
      send_line(1, 1'b0);
      end_frame("R4");

      // R6: frame longer than the buffer
      start_frame(1'b0);
      for (int l = 0; l < 5; l++) send_line(16, 1'b0);
      end_frame("R6");
      check(exp_n == DEPTH, "R6", exp_n, DEPTH);

      // R7: whole frame frozen, then partly frozen
      start_frame(1'b0);
      send_line(10, 1'b1);
      send_line(10, 1'b1);
      end_frame("R7");
      check(obs_n == 0, "R7", obs_n, 0);
      start_frame(1'b0);
      send_line(8, 1'b0);
      send_line(8, 1'b1);
      send_line(8, 1'b0);
      end_frame("R7");

      // R8: surveillance limit at half the buffer
      start_frame(1'b1);
      for (int l = 0; l < 3; l++) send_line(16, 1'b0);
      end_frame("R8");
      check(exp_n == HALF, "R8", exp_n, HALF);

      // R5: vsync mid-frame restarts at address 0
      start_frame(1'b0);
      send_line(10, 1'b0);
      start_frame(1'b0);
      send_line(4, 1'b0);
      end_frame("R5");

      // random frames
      for (int f = 0; f < 24; f++) begin
         int nl;
         start_frame(1'($urandom % 2));
         nl = 1 + int'($urandom % 6);
         for (int l = 0; l < nl; l++)
            send_line(int'($urandom % 21), ($urandom % 4) == 0);
         end_frame(surv_en ? "R8" : "R6");
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: act=hung exp=done");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule